// File: doc/BRIEF.md
# Signed Power-of-Two Divider by Shifts

This unit divides a 32-bit two's-complement dividend by two raised to a 5-bit shift amount and presents the quotient in the same cycle. The result is rounded toward zero, the rule that C signed division follows. It uses no divider circuit. The unit takes the magnitude of the dividend, shifts that magnitude right logically, and then restores the sign by negating the shifted value when the dividend was negative.

A plain arithmetic right shift gives a different answer for negative dividends that are not exact multiples of the divisor. Such a shift rounds toward minus infinity, so -7 shifted by one gives -4, while this unit gives -3. The most-negative dividend is handled with no special case. Its magnitude wraps to the same bit pattern, and the logical shift treats that pattern as unsigned 2^31, so the quotient still comes out right.

Shift amounts 0 to 30 are defined. A shift amount of 31 gives an unspecified result.

Top module: `pow2_trunc_div`

## Requirements
- R1: With shift amount 0, the quotient equals the dividend for every dividend value, including -2^31.
- R2: For a non-negative dividend, the quotient is the dividend shifted right logically by the shift amount (0 to 30).
- R3: For a negative dividend, the quotient is the negation of (the dividend's magnitude shifted right logically), which rounds toward zero. For example, -7 with shift 1 gives -3, and -9 with shift 3 gives -1.
- R4: For the dividend -2^31 (bit pattern 0x80000000) and shift s from 0 to 30, the quotient is -2^(31-s). For example, shift 1 gives 0xC0000000 and shift 30 gives 0xFFFFFFFE.
- R5: The quotient is a purely combinational function of the inputs. It follows an input change with no clock edge in between.
- R6: When the dividend's magnitude is below 2^s, the quotient is 0 for either sign. The quotient is never negative for a non-negative dividend and never positive for a negative one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend_i | input | 32 | Two's-complement dividend |
| shamt_i | input | 5 | Exponent s of the divisor 2^s, valid range 0 to 30 |
| quot_o | output | 32 | Two's-complement quotient, rounded toward zero |

## Verification
The bench targets negative dividends that are not exact multiples of the divisor, where an arithmetic-shift design would return a value one too low. It also targets small negative dividends that must collapse to 0; a shift-based design returns -1 for these instead. The most-negative dividend is exercised at every shift. A design that sign-extends the magnitude, or that special-cases the wrapped negation, returns a wrong sign or a wrong power of two there. Random dividends at every valid shift are compared against truncating integer division, and a pair of input changes between clock edges confirms that no register sits in the path.

// File: rtl/pow2_div_pkg.sv
package pow2_div_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SHAMT_W = $clog2(DATA_W);

  typedef logic [DATA_W-1:0]  word_t;
  typedef logic [SHAMT_W-1:0] shamt_t;
endpackage

// File: rtl/pow2_cond_negate.sv
module pow2_cond_negate #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic             neg_i,
  output logic [WIDTH-1:0] val_o
);
  logic [WIDTH-1:0] inverted;

  always_comb begin
    inverted = ~val_i;
    val_o    = neg_i ? (inverted + {{(WIDTH-1){1'b0}}, 1'b1}) : val_i;
  end

  // R6: a zero input stays zero whether or not it is negated
  always_comb begin
    if (val_i == '0) begin
      assert_zero_stays_R6: assert (val_o == '0);
    end
  end
endmodule

// File: rtl/pow2_log_shifter.sv
module pow2_log_shifter #(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned SHAMT_W = 5
) (
  input  logic [WIDTH-1:0]   val_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [WIDTH-1:0]   val_o
);
  logic [WIDTH-1:0] stage [SHAMT_W+1];

  assign stage[0] = val_i;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    always_comb begin
      if (shamt_i[k]) begin
        stage[k+1] = stage[k] >> STEP;
      end else begin
        stage[k+1] = stage[k];
      end
    end
  end

  assign val_o = stage[SHAMT_W];

  // R2: a logical right shift never grows the unsigned value and
  // leaves the top bit clear for any non-zero shift
  always_comb begin
    assert_shift_no_grow_R2: assert (val_o <= val_i);
    if (shamt_i != '0) begin
      assert_shift_top_clear_R2: assert (val_o[WIDTH-1] == 1'b0);
    end
  end
endmodule

// File: rtl/pow2_trunc_div.sv
module pow2_trunc_div
  import pow2_div_pkg::*;
(
  input  logic [31:0] dividend_i,
  input  logic [4:0]  shamt_i,
  output logic [31:0] quot_o
);
  localparam int unsigned SIGN_BIT = DATA_W - 1;

  word_t magnitude;
  word_t shifted;
  logic  is_neg;

  assign is_neg = dividend_i[SIGN_BIT];

  pow2_cond_negate #(.WIDTH(DATA_W)) u_abs (
    .val_i (dividend_i),
    .neg_i (is_neg),
    .val_o (magnitude)
  );

  pow2_log_shifter #(.WIDTH(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .val_i   (magnitude),
    .shamt_i (shamt_i),
    .val_o   (shifted)
  );

  pow2_cond_negate #(.WIDTH(DATA_W)) u_sign (
    .val_i (shifted),
    .neg_i (is_neg),
    .val_o (quot_o)
  );

  // Checking aids: the quotient scaled back up must lie in the
  // truncation window around the dividend
  logic signed [63:0] chk_x;
  logic signed [63:0] chk_q;
  logic signed [63:0] chk_back;
  logic signed [63:0] chk_step;

  always_comb begin
    chk_x    = 64'(signed'(dividend_i));
    chk_q    = 64'(signed'(quot_o));
    chk_back = chk_q <<< shamt_i;
    chk_step = 64'sd1 <<< shamt_i;
  end

  always_comb begin
    if (shamt_i == 5'd0) begin
      assert_identity_shift0_R1: assert (quot_o == dividend_i);
    end
    if (shamt_i != 5'd31) begin
      if (!is_neg) begin
        assert_pos_window_R2: assert (chk_back <= chk_x && chk_x - chk_back < chk_step);
      end else begin
        assert_round_zero_R3: assert (chk_back >= chk_x && chk_back - chk_x < chk_step);
      end
      if (dividend_i == 32'h8000_0000) begin
        assert_most_neg_R4: assert (chk_q == -(64'sd1 <<< (6'd31 - {1'b0, shamt_i})));
      end
      if (!is_neg) begin
        assert_sign_pos_R6: assert (quot_o[SIGN_BIT] == 1'b0);
      end else begin
        assert_sign_neg_R6: assert (quot_o[SIGN_BIT] == 1'b1 || quot_o == '0);
      end
    end
  end
endmodule

// File: tb/sim_pow2_trunc_div.sv
module sim_pow2_trunc_div;
  logic        clk;
  logic [31:0] dividend;
  logic [4:0]  shamt;
  logic [31:0] quot;
  int          checks;
  int          failures;
  int          cycles;
  bit          done;

  pow2_trunc_div u0 (
    .dividend_i (dividend),
    .shamt_i    (shamt),
    .quot_o     (quot)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct packed {
    logic [31:0] x;
    logic [4:0]  s;
    logic [31:0] q;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{32'd7,          5'd1,  32'd3},
    '{-32'sd7,        5'd1,  -32'sd3},
    '{-32'sd7,        5'd0,  -32'sd7},
    '{-32'sd1,        5'd1,  32'd0},
    '{-32'sd1,        5'd30, 32'd0},
    '{32'h8000_0000,  5'd0,  32'h8000_0000},
    '{32'h8000_0000,  5'd1,  32'hC000_0000},
    '{32'h8000_0000,  5'd30, 32'hFFFF_FFFE},
    '{32'h7FFF_FFFF,  5'd30, 32'd1},
    '{32'h7FFF_FFFF,  5'd0,  32'h7FFF_FFFF},
    '{-32'sd8,        5'd3,  -32'sd1},
    '{-32'sd9,        5'd3,  -32'sd1},
    '{-32'sd15,       5'd3,  -32'sd1},
    '{-32'sd16,       5'd3,  -32'sd2},
    '{32'd100,        5'd4,  32'd6},
    '{-32'sd100,      5'd4,  -32'sd6},
    '{32'd0,          5'd5,  32'd0}
  };

  function automatic string tag_for(input logic [31:0] x, input logic [4:0] s);
    if (s == 5'd0)                return "R1";
    else if (x == 32'h8000_0000)  return "R4";
    else if (x[31])               return "R3";
    else                          return "R2";
  endfunction

  function automatic logic [31:0] ref_div(input logic [31:0] x, input logic [4:0] s);
    longint xv;
    longint dv;
    xv = longint'(signed'(x));
    dv = longint'(1) << s;
    return 32'(xv / dv);
  endfunction

  task automatic compare(input string req, input logic [31:0] exp);
    checks++;
    if (quot !== exp) begin
      failures++;
      $display("FAIL %s x=%h s=%0d actual=%h expected=%h", req, dividend, shamt, quot, exp);
    end
  endtask

  task automatic apply(input logic [31:0] x, input logic [4:0] s);
    @(posedge clk);
    dividend = x;
    shamt    = s;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks   = 0;
    failures = 0;
    cycles   = 0;
    done     = 1'b0;
    dividend = '0;
    shamt    = '0;

    // Vector table: fixed cases with hand-derived quotients
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].x, VECS[i].s);
      compare(tag_for(VECS[i].x, VECS[i].s), VECS[i].q);
    end

    // R6: small magnitudes collapse to zero for both signs
    apply(-32'sd5, 5'd3);  compare("R6", 32'd0);
    apply(32'd5, 5'd3);    compare("R6", 32'd0);
    apply(-32'sd1, 5'd29); compare("R6", 32'd0);

    // R5: output follows inputs with no clock edge in between
    @(posedge clk);
    #0.5 dividend = -32'sd7; shamt = 5'd1;
    #0.5 compare("R5", -32'sd3);
    #0.5 dividend = 32'd64; shamt = 5'd2;
    #0.5 compare("R5", 32'd16);

    // Edge and random dividends at every valid shift
    for (int s = 0; s <= 30; s++) begin
      logic [31:0] edges [6];
      edges[0] = 32'h8000_0000;
      edges[1] = 32'hFFFF_FFFF;
      edges[2] = 32'd1;
      edges[3] = 32'h7FFF_FFFF;
      edges[4] = 32'h8000_0001;
      edges[5] = -(32'd1 << s) - 32'd1;
      for (int e = 0; e < 6; e++) begin
        apply(edges[e], 5'(s));
        compare(tag_for(edges[e], 5'(s)), ref_div(edges[e], 5'(s)));
      end
      for (int r = 0; r < 16; r++) begin
        logic [31:0] rx;
        rx = $urandom();
        apply(rx, 5'(s));
        compare(tag_for(rx, 5'(s)), ref_div(rx, 5'(s)));
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule